// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sorts a 32-bit processor address into one of six programmable address windows. Each window holds a base page, a size mask kept in 64 KiB units, a 4-bit target identifier, an 8-bit attribute code and an enable bit. For every incoming address, the decoder compares the upper address bits against all enabled windows at once. It reports a hit flag, the number of the window that matched, and that window's target and attribute. The decode path is purely combinational from the address input to the outputs. Only the window configuration is held in registers.

Software programs the windows through a one-cycle write port. Each write selects a window, selects one of three fields and supplies a 32-bit data word. The size mask must be a thermometer code: a run of ones starting at bit 0 and zeros above it. Each additional one doubles the window size, and a mask of zero gives the smallest window of 64 KiB. A mask write that breaks this rule raises an error flag. A separate combinational helper converts a byte count into the matching mask encoding, so software can derive masks from sizes.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset every window is disabled, `hit_o` is low for any address and `mask_err_o` is low.
- R2: An enabled window matches when `addr_i[31:16]` equals its base bits [31:16] in every bit position where its size mask is 0. Address bits [15:0] never affect the match.
- R3: A size mask of 0x0000 gives a 64 KiB window. The window's first and last addresses hit, and the addresses one below and one above it miss.
- R4: A mask of N low ones gives a window of 2^N × 64 KiB. For example, 0x00FF covers exactly 16 MiB from the base.
- R5: A window whose enable bit is 0 never hits, even when its base and mask cover the address.
- R6: When several enabled windows match, the one with the lowest number wins.
- R7: On a miss, `hit_o`, `win_o`, `target_o` and `attr_o` are all zero.
- R8: On a hit, `win_o`, `target_o` and `attr_o` carry the winning window's number, target and attribute.
- R9: A write with `cfg_we` high updates the selected window on the next clock edge. Field 0 stores `cfg_wdata[31:16]` as the base. Field 1 stores `cfg_wdata[15:0]` as the mask. Field 2 stores enable from bit 31, attribute from bits 15:8 and target from bits 3:0. Writes to field 3, or to window numbers 6 and 7, change nothing, including `mask_err_o`.
- R10: A mask write to a valid window sets `mask_err_o` to 1 if the data is not a thermometer code and to 0 if it is. Writes to other fields leave the flag unchanged.
- R11: `size_mask_o` is computed from `size_bytes_i` as follows. Start with half the byte count. Set one result bit per halving, from bit 0 upward, while the value is at least 0x10000. Keep the low 16 bits.
- R12: The converter maps 256 MiB to 0x0FFF, 128 MiB to 0x07FF, 16 MiB to 0x00FF, 64 KiB and 0 to 0x0000, 0x30000 to 0x0001 and 0xFFFFFFFF to 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Window number to write |
| cfg_field_i | input | 2 | Field select: 0 base, 1 mask, 2 control, 3 none |
| cfg_wdata_i | input | 32 | Write data |
| mask_err_o | output | 1 | Last mask write was not a thermometer code |
| addr_i | input | 32 | Address to decode |
| hit_o | output | 1 | Some enabled window matches |
| win_o | output | 3 | Winning window number |
| target_o | output | 4 | Target identifier of the winner |
| attr_o | output | 8 | Attribute code of the winner |
| size_bytes_i | input | 32 | Byte count for the size helper |
| size_mask_o | output | 16 | Mask encoding of `size_bytes_i` |

## Verification
The decoder is probed with addresses at and just beyond the edges of windows of three different sizes. These probes separate a correct mask comparison from one that is off by a page or that ignores the mask. Addresses that fall in two overlapping windows, probed both before and after the lower window is disabled, distinguish priority order from enable gating. A clear miss checks that all outputs go to zero. The mask-error flag is driven through invalid and valid writes, plus writes to other fields and to out-of-range windows, to show that only the relevant writes change it. Byte sizes that are powers of two, zero, a non-power of two and the maximum show whether the converter counts halvings correctly and saturates correctly.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 16;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int TGT_W      = 4;
  localparam int ATTR_W     = 8;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] mask;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
  } win_cfg_t;

  function automatic logic is_thermo(input logic [PAGE_W-1:0] m);
    logic [PAGE_W-1:0] inc;
    inc = m + 1'b1;
    return (m & inc) == '0;
  endfunction
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
  import addrwin_pkg::*;
#(
  parameter int NWIN  = 6,
  parameter int SEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        field_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output win_cfg_t          cfg_o [NWIN],
  output logic              mask_err_o
);
  win_cfg_t cfg_d [NWIN];
  win_cfg_t cfg_q [NWIN];
  logic     err_d, err_q;
  logic     sel_ok;
  cfg_field_e fld;

  assign fld    = cfg_field_e'(field_i);
  assign sel_ok = (32'(sel_i) < NWIN);

  always_comb begin
    err_d = err_q;
    for (int i = 0; i < NWIN; i++) begin
      cfg_d[i] = cfg_q[i];
      if (we_i && sel_ok && (32'(sel_i) == i)) begin
        unique case (fld)
          FLD_BASE: cfg_d[i].base = wdata_i[ADDR_W-1:PAGE_SHIFT];
          FLD_MASK: cfg_d[i].mask = wdata_i[PAGE_W-1:0];
          FLD_CTRL: begin
            cfg_d[i].en   = wdata_i[ADDR_W-1];
            cfg_d[i].attr = wdata_i[8 +: ATTR_W];
            cfg_d[i].tgt  = wdata_i[TGT_W-1:0];
          end
          default: ;
        endcase
      end
    end
    if (we_i && sel_ok && (fld == FLD_MASK)) begin
      err_d = !is_thermo(wdata_i[PAGE_W-1:0]);
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= '0;
      end else if (we_i) begin
        cfg_q[g] <= cfg_d[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (we_i) begin
      err_q <= err_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign mask_err_o = err_q;

  // R10
  mask_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_ok && fld == FLD_MASK) |=>
      (mask_err_o == !is_thermo($past(wdata_i[PAGE_W-1:0]))));

  // R9
  ignored_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_ok) |=> $stable(mask_err_o));
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
  import addrwin_pkg::*;
#(
  parameter int NWIN  = 6,
  parameter int SEL_W = 3
) (
  input  win_cfg_t          cfg_i [NWIN],
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NWIN-1:0]   match_o,
  output logic              hit_o,
  output logic [SEL_W-1:0]  win_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic [PAGE_W-1:0] page;
  assign page = addr_i[ADDR_W-1:PAGE_SHIFT];

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign match_o[g] = cfg_i[g].en &&
      (((page ^ cfg_i[g].base) & ~cfg_i[g].mask) == '0);
  end

  always_comb begin
    hit_o  = 1'b0;
    win_o  = '0;
    tgt_o  = '0;
    attr_o = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match_o[i]) begin
        hit_o  = 1'b1;
        win_o  = SEL_W'(i);
        tgt_o  = cfg_i[i].tgt;
        attr_o = cfg_i[i].attr;
      end
    end
  end
endmodule

// File: rtl/addrwin_sizeenc.sv
module addrwin_sizeenc
  import addrwin_pkg::*;
(
  input  logic [ADDR_W-1:0] bytes_i,
  output logic [PAGE_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;

  logic [ADDR_W-1:0] run;
  logic [ADDR_W-1:0] ones;

  always_comb begin
    run  = bytes_i >> 1;
    ones = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (run >= PAGE_BYTES) begin
        ones[i] = 1'b1;
        run     = run >> 1;
      end
    end
    mask_o = ones[PAGE_W-1:0];
  end

  // R11
  always_comb begin
    enc_thermo_chk: assert (is_thermo(mask_o) || $isunknown(bytes_i));
  end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
  import addrwin_pkg::*;
#(
  parameter int NWIN = 6,
  localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              mask_err_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  win_o,
  output logic [TGT_W-1:0]  target_o,
  output logic [ATTR_W-1:0] attr_o,
  input  logic [ADDR_W-1:0] size_bytes_i,
  output logic [PAGE_W-1:0] size_mask_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  win_cfg_t        cfg [NWIN];
  logic [NWIN-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  addrwin_regs #(.NWIN(NWIN), .SEL_W(SEL_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .field_i    (cfg_field_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg),
    .mask_err_o (mask_err_o)
  );

  addrwin_match #(.NWIN(NWIN), .SEL_W(SEL_W)) i_match (
    .cfg_i   (cfg),
    .addr_i  (addr_i),
    .match_o (match),
    .hit_o   (hit_o),
    .win_o   (win_o),
    .tgt_o   (target_o),
    .attr_o  (attr_o)
  );

  addrwin_sizeenc i_sizeenc (
    .bytes_i (size_bytes_i),
    .mask_o  (size_mask_o)
  );

  // R7
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !hit_o |-> (win_o == '0 && target_o == '0 && attr_o == '0));

  // R5
  hit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    hit_o |-> cfg[win_o].en);

  // R6
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    hit_o |-> ((match & ((NWIN'(1) << win_o) - NWIN'(1))) == '0));

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    $rose(rst_n_s) |-> (!hit_o && !mask_err_o));
endmodule

// File: tb/test_addrwin_decoder.sv
module test_addrwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [1:0]  fld = '0;
  logic [31:0] wdata = '0;
  logic        mask_err;
  logic [31:0] addr = '0;
  logic        hit;
  logic [2:0]  win;
  logic [3:0]  tgt;
  logic [7:0]  attr;
  logic [31:0] sbytes = '0;
  logic [15:0] smask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  addrwin_decoder i_addrwin_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_field_i(fld), .cfg_wdata_i(wdata), .mask_err_o(mask_err),
    .addr_i(addr), .hit_o(hit), .win_o(win), .target_o(tgt), .attr_o(attr),
    .size_bytes_i(sbytes), .size_mask_o(smask)
  );

  function automatic logic [31:0] ctrl(bit en, logic [7:0] a, logic [3:0] t);
    return {en, 15'd0, a, 4'd0, t};
  endfunction

  task automatic wr(input logic [2:0] s, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; fld = f; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic dec(input string req, input logic [31:0] a, input bit eh,
                     input logic [2:0] ew, input logic [3:0] et, input logic [7:0] ea);
    addr = a;
    #1;
    checks++;
    if (hit !== eh || win !== ew || tgt !== et || attr !== ea) begin
      fails++;
      $display("FAIL %s addr=%h got hit=%0b win=%0d tgt=%h attr=%h exp hit=%0b win=%0d tgt=%h attr=%h",
               req, a, hit, win, tgt, attr, eh, ew, et, ea);
    end
  endtask

  task automatic err_is(input string req, input bit e);
    #1;
    checks++;
    if (mask_err !== e) begin
      fails++;
      $display("FAIL %s mask_err got %0b exp %0b", req, mask_err, e);
    end
  endtask

  task automatic conv(input string req, input logic [31:0] b, input logic [15:0] e);
    sbytes = b;
    #1;
    checks++;
    if (smask !== e) begin
      fails++;
      $display("FAIL %s size=%h got %h exp %h", req, b, smask, e);
    end
  endtask

  task automatic t_reset;
    dec("R1", 32'h0000_0000, 0, 0, 0, 0);
    dec("R1", 32'h9001_1234, 0, 0, 0, 0);
    err_is("R1", 0);
  endtask

  task automatic t_program;
    wr(0, 0, 32'h9000_ABCD); wr(0, 1, 32'h0000_0FFF); wr(0, 2, ctrl(1, 8'hE8, 4'h4));
    wr(1, 0, 32'h9001_0000); wr(1, 1, 32'h0);         wr(1, 2, ctrl(1, 8'hE0, 4'h4));
    wr(2, 0, 32'hD800_0000); wr(2, 1, 32'h0000_07FF); wr(2, 2, ctrl(1, 8'h2F, 4'h1));
    wr(3, 0, 32'hE800_0000); wr(3, 1, 32'h0000_07FF); wr(3, 2, ctrl(1, 8'h1E, 4'h1));
    wr(4, 0, 32'hF800_0000); wr(4, 1, 32'h0000_07FF); wr(4, 2, ctrl(1, 8'h0F, 4'h1));
    wr(5, 0, 32'hFB00_0000); wr(5, 1, 32'h0);         wr(5, 2, ctrl(1, 8'h01, 4'h3));
    err_is("R10", 0);
  endtask

  task automatic t_decode;
    dec("R6 R8", 32'h9001_1234, 1, 0, 4'h4, 8'hE8);
    dec("R8",    32'hD812_3456, 1, 2, 4'h1, 8'h2F);
    dec("R2",    32'hEFFF_FFFF, 1, 3, 4'h1, 8'h1E);
    dec("R6",    32'hFB00_0010, 1, 4, 4'h1, 8'h0F);
    dec("R7",    32'h1000_0000, 0, 0, 0, 0);
    dec("R2",    32'h9FFF_FFFF, 1, 0, 4'h4, 8'hE8);
    dec("R2",    32'hA000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_enable_small;
    wr(0, 2, ctrl(0, 8'hE8, 4'h4));
    dec("R5 R6", 32'h9001_1234, 1, 1, 4'h4, 8'hE0);
    dec("R3",    32'h9001_0000, 1, 1, 4'h4, 8'hE0);
    dec("R3",    32'h9001_FFFF, 1, 1, 4'h4, 8'hE0);
    dec("R3",    32'h9002_0000, 0, 0, 0, 0);
    dec("R3 R5", 32'h9000_FFFF, 0, 0, 0, 0);
  endtask

  task automatic t_mask16m;
    wr(2, 1, 32'h0000_00FF);
    dec("R4", 32'hD800_0000, 1, 2, 4'h1, 8'h2F);
    dec("R4", 32'hD8FF_FFFF, 1, 2, 4'h1, 8'h2F);
    dec("R4", 32'hD900_0000, 0, 0, 0, 0);
  endtask

  task automatic t_ignored;
    wr(1, 3, 32'h0000_0000);
    dec("R9", 32'h9001_1234, 1, 1, 4'h4, 8'hE0);
    wr(6, 2, ctrl(1, 8'h55, 4'h7));
    wr(7, 1, 32'h0000_00F0);
    err_is("R9", 0);
    dec("R9", 32'h1000_0000, 0, 0, 0, 0);
  endtask

  task automatic t_mask_err;
    wr(3, 1, 32'h0000_00F0);
    err_is("R10", 1);
    wr(3, 2, ctrl(1, 8'h1E, 4'h1));
    err_is("R10", 1);
    wr(6, 1, 32'h0000_0000);
    err_is("R9", 1);
    wr(3, 1, 32'h0000_07FF);
    err_is("R10", 0);
    dec("R2", 32'hE800_0000, 1, 3, 4'h1, 8'h1E);
  endtask

  task automatic t_convert;
    conv("R12", 32'h1000_0000, 16'h0FFF);
    conv("R12", 32'h0800_0000, 16'h07FF);
    conv("R12", 32'h0100_0000, 16'h00FF);
    conv("R12", 32'h0001_0000, 16'h0000);
    conv("R12", 32'h0000_0000, 16'h0000);
    conv("R11", 32'h0003_0000, 16'h0001);
    conv("R11", 32'hFFFF_FFFF, 16'h7FFF);
    conv("R11", 32'h0001_FFFF, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_program();
    t_decode();
    t_enable_small();
    t_mask16m();
    t_ignored();
    t_mask_err();
    t_convert();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule